// File: doc/BRIEF.md
# NRZI Channel-Bit Transmit Serializer

This block converts a stream of data words into a non-return-to-zero-inverted channel bit stream for a simple modulator. One channel bit leaves on every bit-period enable while transmission is on. A zero data bit flips the line level and a one data bit keeps it. Framing, flag insertion and bit stuffing are done upstream. This block only serializes and encodes.

The word boundary is found from a marker bit, not from a bit counter. Each word is loaded into a shift register that is one bit wider than the word, with a one placed above the word's MSB. The register shifts right once per enable. When only the marker, or nothing, is left, a new word is due.

The encoder is one period ahead of the line. On each enable the line first takes the level that was computed on the previous enable, and only then is the next level derived. If the upstream source has no word ready when one is due, an all-ones word is loaded, so the line holds its level instead of stalling. A transmit-enable input parks the line at its idle level and freezes the encoder.

Top module: `nrzi_tx_serializer`

## Requirements
- R1: After reset, `line_o` is at the idle level (0 by default) and `word_ready_o` is low. The shift register is empty after reset, so the first enable with transmission on raises `word_ready_o`.
- R2: `word_ready_o` is high only in a cycle where `bit_en_i` and `tx_en_i` are both high. It rises on the first such enable after reset and then on exactly every WORD_W-th enable after that.
- R3: A word is accepted in a cycle where `word_ready_o` and `word_valid_i` are both high. Its WORD_W data bits are then sent on the next WORD_W enables.
- R4: The bits of each word are sent starting with bit 0 (LSB first) and ending with bit WORD_W-1.
- R5: On each enable, `line_o` takes the level computed on the previous enable, so the line is one period behind the encoder. The first enable after reset drives level 0.
- R6: The encoder derives each next level as the inverse of (current level XOR data bit). A data 1 keeps the level and a data 0 toggles it.
- R7: If `word_valid_i` is low while `word_ready_o` is high, an all-ones word is loaded. The line then holds one level for WORD_W enables.
- R8: While `tx_en_i` is low, `line_o` is at IDLE_LEVEL from the next clock edge on. Enables are ignored and no word is requested. When `tx_en_i` returns high, encoding resumes exactly where it stopped.
- R9: While transmitting, `line_o` changes only at an edge where `bit_en_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle pulse per channel bit period |
| tx_en_i | input | 1 | High to drive the line, low to hold it idle |
| word_i | input | WORD_W | Next data word |
| word_valid_i | input | 1 | `word_i` holds a word to send |
| word_ready_o | output | 1 | A word is taken in this cycle |
| line_o | output | 1 | Registered channel bit to the modulator |

## Verification
The bench decodes the line by comparing successive levels, rebuilds every word, and compares the words in order against what was offered. The words include all-zeros, all-ones, alternating patterns, walking ones and zeros, and pseudo-random words. A design that dropped the one-period pipeline, or inverted the encoding rule, would shift or complement every decoded bit. A design that shifted MSB first would return bit-reversed words. A design that detected the marker one step early or late would request words at the wrong period and lose or repeat bits. Starvation gaps check that the line holds flat, where a design that stalled or loaded stale data would toggle. Transmit-enable drops in mid-word check that the line parks idle and that the stream continues seamlessly afterwards.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  localparam int unsigned DEF_WORD_W = 16;

  // NRZI rule: a one keeps the level, a zero flips it
  function automatic logic nrzi_next(input logic level, input logic data);
    return ~(level ^ data);
  endfunction
endpackage

// File: rtl/nrzi_tx_shifter.sv
module nrzi_tx_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              req_o,
  output logic              data_bit_o
);
  localparam int unsigned SH_W = WORD_W + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_eff;
  logic            spent;

  // only the marker (or nothing) left
  assign spent = ~|sh_q[SH_W-1:1];
  assign req_o = step_i & spent;

  always_comb begin
    sh_eff = sh_q;
    if (spent) sh_eff = {1'b1, (word_valid_i ? word_i : {WORD_W{1'b1}})};
  end

  assign data_bit_o = sh_eff[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (step_i) sh_q <= sh_eff >> 1;
  end
endmodule

// File: rtl/nrzi_tx_encoder.sv
module nrzi_tx_encoder
  import nrzi_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic data_bit_i,
  output logic chan_o
);
  logic chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chan_q <= 1'b0;
    else if (step_i) chan_q <= nrzi_next(chan_q, data_bit_i);
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic step_i,
  input  logic chan_i,
  output logic line_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       line_q <= IDLE_LEVEL;
    else if (!tx_en_i) line_q <= IDLE_LEVEL;
    else if (step_i)   line_q <= chan_i;
  end

  assign line_o = line_q;
endmodule

// File: rtl/nrzi_tx_serializer.sv
module nrzi_tx_serializer #(
  parameter int unsigned WORD_W     = nrzi_tx_pkg::DEF_WORD_W,
  parameter bit          IDLE_LEVEL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              tx_en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              line_o
);
  logic step;
  logic data_bit;
  logic chan;

  assign step = bit_en_i & tx_en_i;

  nrzi_tx_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .word_i      (word_i),
    .word_valid_i(word_valid_i),
    .req_o       (word_ready_o),
    .data_bit_o  (data_bit)
  );

  nrzi_tx_encoder u_encoder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .data_bit_i(data_bit),
    .chan_o    (chan)
  );

  nrzi_tx_line #(.IDLE_LEVEL(IDLE_LEVEL)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tx_en_i(tx_en_i),
    .step_i (step),
    .chan_i (chan),
    .line_o (line_o)
  );
endmodule

// File: rtl/nrzi_tx_serializer_chk.sv
module nrzi_tx_serializer_chk #(
  parameter int unsigned WORD_W     = 16,
  parameter bit          IDLE_LEVEL = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic tx_en_i,
  input logic word_ready_o,
  input logic line_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

  logic             fire;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire = bit_en_i & tx_en_i;

  // enables since the last request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fire) begin
      if (word_ready_o) begin
        seen_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  ready_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> (bit_en_i && tx_en_i));

  // R2
  ready_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> (!seen_q || cnt_q == CNT_W'(WORD_W - 1)));

  // R2
  ready_not_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !word_ready_o) |-> (seen_q && cnt_q < CNT_W'(WORD_W - 1)));

  // R8
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (line_o == IDLE_LEVEL));

  // R9
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !bit_en_i) |=> $stable(line_o));
endmodule

bind nrzi_tx_serializer nrzi_tx_serializer_chk #(
  .WORD_W    (WORD_W),
  .IDLE_LEVEL(IDLE_LEVEL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .tx_en_i     (tx_en_i),
  .word_ready_o(word_ready_o),
  .line_o      (line_o)
);

// File: tb/nrzi_tx_serializer_test.sv
`timescale 1ns/1ps
module nrzi_tx_serializer_test;
  localparam int unsigned W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bit_en_i = 1'b0;
  logic         tx_en_i = 1'b1;
  logic [W-1:0] word_i = '0;
  logic         word_valid_i = 1'b0;
  logic         word_ready_o;
  logic         line_o;

  nrzi_tx_serializer #(.WORD_W(W), .IDLE_LEVEL(1'b0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .tx_en_i(tx_en_i),
    .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .line_o(line_o)
  );

  always #4 clk_i = ~clk_i;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // reference state
  logic [W-1:0] loaded [0:1023];
  int           n_loaded = 0;
  int           n_dec = 0;
  logic [W-1:0] cur_word;
  int           bit_idx = W;
  logic         exp_chan = 1'b0;
  logic         prev_line;
  bit           have_prev = 1'b0;
  logic [W-1:0] dec_word;
  int           dec_cnt = 0;
  logic [31:0]  lfsr = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit period: enable cycle then one quiet cycle
  task automatic period(input bit tx, input bit vld, input logic [W-1:0] w);
    bit   rdy;
    bit   exp_rdy;
    logic d;
    @(negedge clk_i);
    tx_en_i = tx; bit_en_i = 1'b1; word_valid_i = vld; word_i = w;
    #1;
    rdy = word_ready_o;
    exp_rdy = tx && (bit_idx == W);
    check(rdy == exp_rdy, "R2 ready timing", rdy, exp_rdy);
    if (tx && rdy) begin
      cur_word = vld ? w : {W{1'b1}};   // R3 / R7
      loaded[n_loaded] = cur_word;
      n_loaded++;
      bit_idx = 0;
    end
    @(negedge clk_i);
    bit_en_i = 1'b0;
    if (!tx) begin
      check(line_o == 1'b0, "R8 idle level", line_o, 0);
    end else begin
      // R5: line shows level computed one period earlier
      check(line_o == exp_chan, "R5/R6 line level", line_o, exp_chan);
      if (have_prev) begin
        dec_word = {(line_o == prev_line), dec_word[W-1:1]};
        dec_cnt++;
        if (dec_cnt == W) begin
          // R4: LSB-first reassembly returns the word in order
          check(dec_word == loaded[n_dec], "R3/R4 decoded word", dec_word, loaded[n_dec]);
          n_dec++;
          dec_cnt = 0;
        end
      end
      prev_line = line_o;
      have_prev = 1'b1;
      d = cur_word[bit_idx];
      exp_chan = ~(exp_chan ^ d);
      bit_idx++;
    end
    @(negedge clk_i);
    if (tx) check(line_o == prev_line, "R9 line stable", line_o, prev_line);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    period(1'b1, 1'b1, w);
    for (int i = 1; i < W; i++) period(1'b1, 1'b1, ~w); // not a request cycle
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(line_o == 1'b0, "R1 reset line", line_o, 0);
    check(word_ready_o == 1'b0, "R1 reset ready", word_ready_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(line_o == 1'b0, "R1 line after reset", line_o, 0);

    // R1 first enable requests; R6 edge patterns
    send_word(16'h0000);
    send_word(16'hFFFF);
    send_word(16'hAAAA);
    send_word(16'h5555);
    for (int i = 0; i < W; i++) send_word(16'h1 << i);
    for (int i = 0; i < W; i++) send_word(~(16'h1 << i));

    // R7 starvation: line must stay flat for a whole word
    begin
      logic l0;
      period(1'b1, 1'b0, 16'h0123);
      l0 = line_o;
      for (int i = 1; i < W; i++) period(1'b1, 1'b1, 16'h0000);
      period(1'b1, 1'b1, 16'hC3A5);
      check(line_o == l0, "R7 flat line on starvation", line_o, l0);
      for (int i = 1; i < W; i++) period(1'b1, 1'b1, 16'h0000);
    end

    // R8 mid-word transmit drop, then resume
    for (int k = 0; k < 4; k++) begin
      send_word(16'h9E37 ^ 16'(k * 4111));
    end
    period(1'b1, 1'b1, 16'h7F01);
    for (int i = 0; i < 5; i++) period(1'b1, 1'b1, 16'h0);
    for (int i = 0; i < 7; i++) period(1'b0, 1'b1, 16'hDEAD);
    for (int i = 6; i < W; i++) period(1'b1, 1'b1, 16'h0);
    for (int i = 0; i < 3; i++) period(1'b0, 1'b0, 16'h0);
    send_word(16'h8001);

    // pseudo-random words with occasional starvation
    for (int k = 0; k < 150; k++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      if (lfsr[31:29] == 3'b000) begin
        period(1'b1, 1'b0, lfsr[15:0]);
        for (int i = 1; i < W; i++) period(1'b1, 1'b1, 16'h0);
      end else begin
        send_word(lfsr[23:8]);
      end
    end
    // flush the last word through the decoder
    send_word(16'h0F0F);
    check(n_dec == n_loaded - 1, "R3 all words decoded", n_dec, n_loaded - 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule